// File: doc/BRIEF.md
# Checked System Clock Source Switch

This block picks the system clock from three sources: an external crystal, a low-speed RC oscillator and a high-speed RC oscillator. Each source appears as a one-cycle enable pulse in a single reference clock domain. Each source also has a stable flag. Software requests a source by writing a 3-bit code. Such a write only takes effect while a three-byte unlock key is open. The selected pulse train then passes through a programmable post-divider. The result is the system clock enable.

A request for a source that is not yet stable is not lost. The block records it as the target, raises a switch-fail flag and keeps the old source running. When the target's stable flag goes high, the block completes the switch and clears the flag without further help from software. The changeover itself waits for a cycle in which neither the old nor the new pulse is high. This way no shortened or merged pulse reaches the divider.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the current source is the high-speed RC (code 111), the switch-fail flag is 0, the select field is locked, the divide ratio is 1 and the clock enable is low.
- R2: Three protection writes carrying 0x59, 0x16 and 0x88, in that order, open the select field. The unlocked output rises after the third write.
- R3: A protection write with a wrong byte before the key is complete restarts the key. A wrong byte that equals 0x59 counts as the first byte of a new key.
- R4: Any protection write made while the select field is open locks it again.
- R5: A select write made while the field is locked is ignored. The current source, the target and the fail flag all keep their values.
- R6: Only codes 000 (crystal), 011 (low-speed RC) and 111 (high-speed RC) are accepted. A write of any other code is ignored, even when unlocked.
- R7: An accepted write to a source whose stable flag is 1 sets the fail flag to 0. The source then changes two cycles after the write cycle, provided neither enable pulse is high in between.
- R8: An accepted write to a source whose stable flag is 0 sets the fail flag to 1 and keeps the old source. Once that flag becomes 1, the switch completes and the fail flag clears at the same clock edge.
- R9: The current source changes only at an edge where the pulses of both the old and the new source were low in the preceding cycle.
- R10: With a divide value N, the clock enable is high for one cycle, one cycle after every (N+1)-th pulse of the current source. Writing a new divide value restarts the count.
- R11: Bit 0 of the pulse and stable inputs belongs to the crystal, bit 1 to the low-speed RC and bit 2 to the high-speed RC. Pulses of sources other than the current one have no effect on the clock enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 3 | Per-source enable pulses (bit 0 crystal, 1 low RC, 2 high RC) |
| src_stable | input | 3 | Per-source stable flags, same bit order |
| prot_wr | input | 1 | Write strobe of the protection key register |
| prot_byte | input | 8 | Byte written to the protection key register |
| sel_wr | input | 1 | Write strobe of the source select field |
| sel_code | input | 3 | Requested source code |
| div_wr | input | 1 | Write strobe of the divide value |
| div_val | input | 4 | Divide value N (ratio N+1) |
| cur_sel | output | 3 | Code of the source currently driving the system clock |
| sys_ce | output | 1 | Divided system clock enable |
| sw_fail | output | 1 | Switch-fail flag |
| unlocked | output | 1 | Select field is open for writes |

## Verification
The switch is tried under four input patterns. Targets already stable, with idle pulses, show the plain two-cycle changeover. Targets that are unstable at the write show the pending path and the automatic completion when the flag rises. Old-source pulses held high across the request show that the changeover is deferred to a gap. Reserved codes and writes while locked show that no state is touched. The key sequencer gets the correct key, a broken key, a key restarted by a repeated 0x59, and a relocking write. These tell a sequencer that restarts apart from one that only stalls. The divider is checked at ratios 1 and 3, with pulses on unselected sources mixed in. This separates counting of the selected source from counting of all pulses.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NSRC   = 3;
  localparam int SEL_W  = 3;
  localparam int IDX_W  = 2;
  localparam int KEY_W  = 8;

  localparam logic [SEL_W-1:0] CODE_XTAL = 3'b000;
  localparam logic [SEL_W-1:0] CODE_LRC  = 3'b011;
  localparam logic [SEL_W-1:0] CODE_HRC  = 3'b111;

  localparam logic [KEY_W-1:0] KEY0 = 8'h59;
  localparam logic [KEY_W-1:0] KEY1 = 8'h16;
  localparam logic [KEY_W-1:0] KEY2 = 8'h88;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_K1   = 2'd1,
    LK_K2   = 2'd2,
    LK_OPEN = 2'd3
  } lock_st_e;

  function automatic logic code_ok(input logic [SEL_W-1:0] c);
    return (c == CODE_XTAL) || (c == CODE_LRC) || (c == CODE_HRC);
  endfunction

  function automatic logic [IDX_W-1:0] code_idx(input logic [SEL_W-1:0] c);
    logic [IDX_W-1:0] r;
    case (c)
      CODE_XTAL: r = 2'd0;
      CODE_LRC:  r = 2'd1;
      default:   r = 2'd2;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_wr,
  input  logic [KEY_W-1:0] prot_byte,
  output logic             open_o
);
  lock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (prot_wr) begin
      case (st_q)
        LK_IDLE: st_d = (prot_byte == KEY0) ? LK_K1 : LK_IDLE;
        LK_K1:   st_d = (prot_byte == KEY1) ? LK_K2 :
                        (prot_byte == KEY0) ? LK_K1 : LK_IDLE;
        LK_K2:   st_d = (prot_byte == KEY2) ? LK_OPEN :
                        (prot_byte == KEY0) ? LK_K1 : LK_IDLE;
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign open_o = (st_q == LK_OPEN);

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(prot_wr && (prot_byte == KEY2)));

  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && prot_wr) |=> !open_o);
endmodule

// File: rtl/clksw_select.sv
module clksw_select
  import clksw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [NSRC-1:0]  src_stable,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             open_i,
  output logic [SEL_W-1:0] cur_o,
  output logic             fail_o,
  output logic             tick_o
);
  logic [SEL_W-1:0] cur_q, cur_d, tgt_q, tgt_d;
  logic             fail_q, fail_d;
  logic             wr_ok, tgt_stable, gap, do_sw, pending;

  assign wr_ok      = sel_wr && open_i && code_ok(sel_code);
  assign pending    = (tgt_q != cur_q);
  assign tgt_stable = src_stable[code_idx(tgt_q)];
  assign gap        = !src_tick[code_idx(cur_q)] && !src_tick[code_idx(tgt_q)];
  assign do_sw      = !wr_ok && pending && tgt_stable && gap;

  always_comb begin
    tgt_d  = tgt_q;
    cur_d  = cur_q;
    fail_d = fail_q;
    if (wr_ok) begin
      tgt_d  = sel_code;
      fail_d = !src_stable[code_idx(sel_code)];
    end else begin
      if (do_sw) begin
        cur_d  = tgt_q;
        fail_d = 1'b0;
      end else if (!pending && tgt_stable) begin
        fail_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= CODE_HRC;
      tgt_q  <= CODE_HRC;
      fail_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      tgt_q  <= tgt_d;
      fail_q <= fail_d;
    end
  end

  assign cur_o  = cur_q;
  assign fail_o = fail_q;
  assign tick_o = src_tick[code_idx(cur_q)];

  // R6
  cur_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(cur_q) && code_ok(tgt_q));

  // R9
  gap_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |->
      ($past(src_tick[code_idx(cur_q)]) == 1'b0) &&
      ($past(src_tick[code_idx($past(cur_q))]) == 1'b0));

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !open_i) |=> $stable(tgt_q));

  // R8
  fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(sel_wr && open_i));
endmodule

// File: rtl/clksw_divider.sv
module clksw_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic             ce_o
);
  logic [DIV_W-1:0] div_q, div_d, cnt_q, cnt_d;
  logic             ce_q, ce_d, wrap;

  assign wrap = (cnt_q == div_q);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    ce_d  = 1'b0;
    if (div_wr) begin
      div_d = div_val;
      cnt_d = '0;
    end else if (tick_i) begin
      ce_d  = wrap;
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      ce_q  <= ce_d;
    end
  end

  assign ce_o = ce_q;

  // R10
  ce_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q |-> $past(tick_i && !div_wr));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import clksw_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_tick,
  input  logic [2:0]       src_stable,
  input  logic             prot_wr,
  input  logic [7:0]       prot_byte,
  input  logic             sel_wr,
  input  logic [2:0]       sel_code,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic [2:0]       cur_sel,
  output logic             sys_ce,
  output logic             sw_fail,
  output logic             unlocked
);
  logic open_w, tick_w;

  clksw_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .prot_wr   (prot_wr),
    .prot_byte (prot_byte),
    .open_o    (open_w)
  );

  clksw_select u_select (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_tick   (src_tick),
    .src_stable (src_stable),
    .sel_wr     (sel_wr),
    .sel_code   (sel_code),
    .open_i     (open_w),
    .cur_o      (cur_sel),
    .fail_o     (sw_fail),
    .tick_o     (tick_w)
  );

  clksw_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_w),
    .div_wr  (div_wr),
    .div_val (div_val),
    .ce_o    (sys_ce)
  );

  assign unlocked = open_w;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cur_sel == 3'b111));
endmodule

// File: tb/tb_sysclk_switch.sv
module tb_sysclk_switch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] src_tick, src_stable;
  logic       prot_wr, sel_wr, div_wr;
  logic [7:0] prot_byte;
  logic [2:0] sel_code;
  logic [3:0] div_val;
  logic [2:0] cur_sel;
  logic       sys_ce, sw_fail, unlocked;
  int errs = 0;
  int chks = 0;

  always #4 clk = ~clk;

  sysclk_switch dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_stable(src_stable),
    .prot_wr(prot_wr), .prot_byte(prot_byte), .sel_wr(sel_wr),
    .sel_code(sel_code), .div_wr(div_wr), .div_val(div_val),
    .cur_sel(cur_sel), .sys_ce(sys_ce), .sw_fail(sw_fail), .unlocked(unlocked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic prot(input logic [7:0] b);
    prot_wr = 1'b1; prot_byte = b;
    @(negedge clk);
    prot_wr = 1'b0;
  endtask

  task automatic selw(input logic [2:0] c);
    sel_wr = 1'b1; sel_code = c;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic unlock_key();
    prot(8'h59); prot(8'h16); prot(8'h88);
  endtask

  task automatic t_reset();
    check(cur_sel == 3'b111, "R1 cur_sel", cur_sel, 7);
    check(sw_fail == 1'b0, "R1 sw_fail", sw_fail, 0);
    check(unlocked == 1'b0, "R1 unlocked", unlocked, 0);
    check(sys_ce == 1'b0, "R1 sys_ce", sys_ce, 0);
  endtask

  task automatic t_locked_write();
    selw(3'b011);
    idle(3);
    check(cur_sel == 3'b111, "R5 locked write ignored", cur_sel, 7);
    check(sw_fail == 1'b0, "R5 fail untouched", sw_fail, 0);
  endtask

  task automatic t_key();
    unlock_key();
    check(unlocked == 1'b1, "R2 key opens", unlocked, 1);
    prot(8'h00);
    check(unlocked == 1'b0, "R4 relock", unlocked, 0);
    prot(8'h59); prot(8'h22); prot(8'h16); prot(8'h88);
    check(unlocked == 1'b0, "R3 broken key", unlocked, 0);
    prot(8'h59); prot(8'h59); prot(8'h16); prot(8'h88);
    check(unlocked == 1'b1, "R3 restart on 0x59", unlocked, 1);
  endtask

  task automatic t_reserved();
    selw(3'b001);
    idle(2);
    check(cur_sel == 3'b111, "R6 code 001 ignored", cur_sel, 7);
    selw(3'b101);
    idle(2);
    check(cur_sel == 3'b111, "R6 code 101 ignored", cur_sel, 7);
    check(sw_fail == 1'b0, "R6 fail untouched", sw_fail, 0);
  endtask

  task automatic t_stable_switch();
    selw(3'b000);
    check(sw_fail == 1'b0, "R7 fail cleared", sw_fail, 0);
    check(cur_sel == 3'b111, "R7 not yet switched", cur_sel, 7);
    @(negedge clk);
    check(cur_sel == 3'b000, "R7 switched to crystal", cur_sel, 0);
  endtask

  task automatic t_gap();
    src_tick = 3'b001;
    selw(3'b011);
    idle(4);
    check(cur_sel == 3'b000, "R9 held while old pulse high", cur_sel, 0);
    src_tick = 3'b000;
    @(negedge clk);
    check(cur_sel == 3'b011, "R9 switched in gap", cur_sel, 3);
    idle(1);
  endtask

  task automatic t_fail();
    src_stable = 3'b011;
    selw(3'b111);
    check(sw_fail == 1'b1, "R8 fail set", sw_fail, 1);
    idle(4);
    check(cur_sel == 3'b011, "R8 old source kept", cur_sel, 3);
    check(sw_fail == 1'b1, "R8 fail held", sw_fail, 1);
    src_stable = 3'b111;
    @(negedge clk);
    check(cur_sel == 3'b111, "R8 auto switch", cur_sel, 7);
    check(sw_fail == 1'b0, "R8 fail cleared", sw_fail, 0);
  endtask

  task automatic t_div();
    div_wr = 1'b1; div_val = 4'd2;
    @(negedge clk);
    div_wr = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      src_tick = 3'b100;
      @(negedge clk);
      src_tick = 3'b000;
      check(sys_ce == ((i % 3) == 0), "R10 ratio 3", sys_ce, ((i % 3) == 0));
      src_tick = 3'b011;
      @(negedge clk);
      src_tick = 3'b000;
      check(sys_ce == 1'b0, "R11 other sources ignored", sys_ce, 0);
    end
    div_wr = 1'b1; div_val = 4'd0;
    @(negedge clk);
    div_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      src_tick = 3'b100;
      @(negedge clk);
      src_tick = 3'b000;
      check(sys_ce == 1'b1, "R10 ratio 1", sys_ce, 1);
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, chks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_tick = 3'b000; src_stable = 3'b111;
    prot_wr = 1'b0; prot_byte = 8'h00; sel_wr = 1'b0; sel_code = 3'b000;
    div_wr = 1'b0; div_val = 4'd0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_locked_write();
    t_key();
    t_reserved();
    t_stable_switch();
    t_gap();
    t_fail();
    t_div();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule